// File: doc/BRIEF.md
# Destructive-Read Memory Cycle Policy Controller

This block sits between a small cache and a memory array whose read cycle wipes the stored word, so the word survives only if a write cycle puts it back. For every cache line it keeps a two-bit state that says whether the line is valid, whether the cache copy has been modified, and whether the memory still holds a copy. When the cache fills or evicts a line, the block works out which memory cycles are actually needed and issues them one at a time. Depending on the state, that is a read alone, a read followed by a regenerating write, a write alone, a read followed by a write, or no cycle at all.

A fill request carries the write permission of the page it comes from. A fill from a page without write permission always regenerates the memory copy and leaves the line clean. For a fill from a writable page there are two choices. Below a programmable queue-occupancy threshold, the block regenerates and marks the line clean, in the hope that the line is never modified. At or above the threshold, it skips the regeneration to save a memory cycle and records that memory is empty. A clear command erases a run of consecutive memory lines by issuing plain reads. Processor stores are reported to the block so that a clean line can become dirty.

Top module: `drm_cycle_ctrl`

## Requirements
- R1: After reset every line reads state INVALID (2'b00), and `busy`, `cmd_valid` and `err` are 0.
- R2: A fill (op 2'b00) with `req_writable`=0 issues a read (`cmd_write`=0) and then a write (`cmd_write`=1) to `req_addr`. The line becomes CLEAN (2'b01).
- R3: A writable fill with `q_occ` < `q_thresh` issues a read and then a write to `req_addr`. The line becomes CLEAN.
- R4: A writable fill with `q_occ` >= `q_thresh` issues a single read and no write. The line becomes DIRTY_EMPTY (2'b11).
- R5: A store (op 2'b10) to a CLEAN line makes it DIRTY_KEPT (2'b10). A store to a dirty line leaves it unchanged. Stores are accepted while `busy` is 1.
- R6: Evicting (op 2'b01) a CLEAN line issues no memory cycle and makes the line INVALID.
- R7: Evicting a DIRTY_EMPTY line issues a single write to `req_addr` with no read before it. The line becomes INVALID.
- R8: Evicting a DIRTY_KEPT line issues a read and then a write to `req_addr`. The line becomes INVALID.
- R9: A clear (op 2'b11) with count N issues N reads at `req_addr`, `req_addr`+1, and so on, wrapping modulo 2^ADDR_W, and no writes. With N=0 it issues nothing. No line state changes.
- R10: A command stays on the port with its type and address unchanged until it is taken with `cmd_ready`=1.
- R11: While `busy` is 1, fill, evict and clear requests are ignored: no line state changes and no command is added.
- R12: A store to, or an eviction of, an INVALID line raises `err` for exactly one cycle, in the cycle after the request. It changes no state and issues no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 00 fill, 01 evict, 10 store, 11 clear |
| req_slot | input | IDX_W | Cache line index |
| req_addr | input | ADDR_W | Memory line address (start address for clear) |
| req_writable | input | 1 | Fill comes from a page with write permission |
| req_count | input | CNT_W | Number of lines to clear |
| q_occ | input | QW | Memory access queue occupancy |
| q_thresh | input | QW | Occupancy at which writable fills skip regeneration |
| look_slot | input | IDX_W | Line whose state is shown on `look_state` |
| look_state | output | 2 | State of line `look_slot` |
| busy | output | 1 | Command sequence in progress |
| err | output | 1 | Store or evict to an INVALID line seen last cycle |
| cmd_valid | output | 1 | Memory cycle offered |
| cmd_ready | input | 1 | Memory accepts the offered cycle |
| cmd_write | output | 1 | 0 read cycle, 1 write cycle |
| cmd_addr | output | ADDR_W | Memory line address of the cycle |

## Verification
The assertions watch, on every cycle, properties that hold one cycle at a time. An offered command holds steady while it is stalled. A regenerating write reuses the address of the read just before it. A clean eviction leaves the command port silent, and an eviction of an empty-memory line starts with a write. An error pulse always follows an access to an invalid line. Only the bench scenarios can show that the complete command sequence for each fill and evict path is right, that a clear wraps its address, that the threshold boundary picks the right policy, and that requests arriving during a busy period leave the line table untouched.

// File: rtl/drm_pkg.sv
package drm_pkg;

  typedef enum logic [1:0] {
    LS_INVALID     = 2'b00,
    LS_CLEAN       = 2'b01,
    LS_DIRTY_KEPT  = 2'b10,
    LS_DIRTY_EMPTY = 2'b11
  } line_st_t;

  typedef enum logic [1:0] {
    OP_FILL  = 2'b00,
    OP_EVICT = 2'b01,
    OP_STORE = 2'b10,
    OP_CLEAR = 2'b11
  } req_op_t;

  typedef struct packed {
    logic     do_rd;
    logic     do_wr;
    logic     upd;
    line_st_t nstate;
    logic     err;
  } plan_t;

  localparam plan_t PLAN_NONE = '{do_rd: 1'b0, do_wr: 1'b0, upd: 1'b0,
                                  nstate: LS_INVALID, err: 1'b0};

  // Queue pressure test kept apart so the bench can restate it directly.
  function automatic logic occ_at_limit(input logic [7:0] occ, input logic [7:0] thr);
    return occ >= thr;
  endfunction

  function automatic plan_t fill_plan(input logic writable, input logic congested);
    plan_t p;
    p = PLAN_NONE;
    p.do_rd = 1'b1;
    p.upd   = 1'b1;
    if (writable && congested) begin
      p.do_wr  = 1'b0;
      p.nstate = LS_DIRTY_EMPTY;
    end else begin
      p.do_wr  = 1'b1;
      p.nstate = LS_CLEAN;
    end
    return p;
  endfunction

  function automatic plan_t evict_plan(input line_st_t cur);
    plan_t p;
    p = PLAN_NONE;
    case (cur)
      LS_INVALID:     p.err = 1'b1;
      LS_CLEAN:       p.upd = 1'b1;
      LS_DIRTY_KEPT:  begin p.do_rd = 1'b1; p.do_wr = 1'b1; p.upd = 1'b1; end
      LS_DIRTY_EMPTY: begin p.do_wr = 1'b1; p.upd = 1'b1; end
      default:        p = PLAN_NONE;
    endcase
    p.nstate = LS_INVALID;
    return p;
  endfunction

  function automatic plan_t store_plan(input line_st_t cur);
    plan_t p;
    p = PLAN_NONE;
    if (cur == LS_INVALID) begin
      p.err = 1'b1;
    end else if (cur == LS_CLEAN) begin
      p.upd    = 1'b1;
      p.nstate = LS_DIRTY_KEPT;
    end
    return p;
  endfunction

endpackage

// File: rtl/drm_line_table.sv
module drm_line_table
  import drm_pkg::*;
#(
  parameter int LINES = 8,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_a_idx,
  output line_st_t         rd_a_st,
  input  logic [IDX_W-1:0] rd_b_idx,
  output line_st_t         rd_b_st,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  line_st_t         wr_st
);

  line_st_t st_w [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    line_st_t st_r;
    logic     hit;
    assign hit = wr_en && (wr_idx == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n)   st_r <= LS_INVALID;
      else if (hit) st_r <= wr_st;
    end
    assign st_w[i] = st_r;
  end

  assign rd_a_st = st_w[rd_a_idx];
  assign rd_b_st = st_w[rd_b_idx];

  // R5: only a clean line may be turned into a dirty line with memory intact
  a_r5_kept_from_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_st == LS_DIRTY_KEPT) |-> (st_w[wr_idx] == LS_CLEAN));

  // R12: an invalid line never becomes dirty without a fill
  a_r12_invalid_no_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && st_w[wr_idx] == LS_INVALID) |-> (wr_st != LS_DIRTY_KEPT));

endmodule

// File: rtl/drm_policy.sv
module drm_policy
  import drm_pkg::*;
#(
  parameter int QW = 4
) (
  input  req_op_t         op,
  input  line_st_t        cur,
  input  logic            writable,
  input  logic [QW-1:0]   q_occ,
  input  logic [QW-1:0]   q_thresh,
  output plan_t           plan
);

  logic congested;
  assign congested = occ_at_limit(8'(q_occ), 8'(q_thresh));

  always_comb begin
    case (op)
      OP_FILL:  plan = fill_plan(writable, congested);
      OP_EVICT: plan = evict_plan(cur);
      OP_STORE: plan = store_plan(cur);
      default:  plan = PLAN_NONE;
    endcase
  end

endmodule

// File: rtl/drm_cmd_seq.sv
module drm_cmd_seq #(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_clear,
  input  logic              start_rd,
  input  logic              start_wr,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  start_cnt,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_write,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              busy
);

  typedef enum logic [1:0] {SQ_IDLE, SQ_RD, SQ_WR, SQ_CLR} sq_t;

  sq_t               st_q;
  logic              pend_wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  remain_q;
  logic              fire;

  assign cmd_valid = (st_q != SQ_IDLE);
  assign cmd_write = (st_q == SQ_WR);
  assign cmd_addr  = addr_q;
  assign busy      = cmd_valid;
  assign fire      = cmd_valid && cmd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= SQ_IDLE;
      pend_wr_q <= 1'b0;
      addr_q    <= '0;
      remain_q  <= '0;
    end else begin
      case (st_q)
        SQ_IDLE: if (start) begin
          addr_q    <= start_addr;
          pend_wr_q <= start_wr;
          remain_q  <= start_cnt;
          if (start_clear)   st_q <= SQ_CLR;
          else if (start_rd) st_q <= SQ_RD;
          else               st_q <= SQ_WR;
        end
        SQ_RD: if (fire) st_q <= pend_wr_q ? SQ_WR : SQ_IDLE;
        SQ_WR: if (fire) st_q <= SQ_IDLE;
        SQ_CLR: if (fire) begin
          addr_q   <= addr_q + 1'b1;
          remain_q <= remain_q - 1'b1;
          if (remain_q == CNT_W'(1)) st_q <= SQ_IDLE;
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  // R10: a stalled command keeps its type and address
  a_r10_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_write) && $stable(cmd_addr)));

  // R2: a regenerating write follows its read at the same address
  a_r2_regen_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && st_q == SQ_RD && pend_wr_q) |=> (cmd_valid && cmd_write && $stable(cmd_addr)));

  // R9: a clear sequence is never entered or kept with nothing left to erase
  a_r9_clear_count_live: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_CLR) |-> (remain_q != '0));

endmodule

// File: rtl/drm_cycle_ctrl.sv
module drm_cycle_ctrl
  import drm_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 8,
  parameter int QW     = 4,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [IDX_W-1:0]  req_slot,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_writable,
  input  logic [CNT_W-1:0]  req_count,
  input  logic [QW-1:0]     q_occ,
  input  logic [QW-1:0]     q_thresh,
  input  logic [IDX_W-1:0]  look_slot,
  output logic [1:0]        look_state,
  output logic              busy,
  output logic              err,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_write,
  output logic [ADDR_W-1:0] cmd_addr
);

  req_op_t  op;
  line_st_t cur_st;
  line_st_t look_st;
  plan_t    plan;
  logic     acc;
  logic     acc_evict;
  logic     seq_start;
  logic     is_clear;
  logic     err_q;

  assign op        = req_op_t'(req_op);
  assign is_clear  = (op == OP_CLEAR);
  assign acc       = req_valid && ((op == OP_STORE) || !busy);
  assign acc_evict = acc && (op == OP_EVICT);
  assign seq_start = acc && (is_clear ? (req_count != '0) : (plan.do_rd || plan.do_wr));

  drm_line_table #(.LINES(LINES)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_a_idx (req_slot),
    .rd_a_st  (cur_st),
    .rd_b_idx (look_slot),
    .rd_b_st  (look_st),
    .wr_en    (acc && plan.upd),
    .wr_idx   (req_slot),
    .wr_st    (plan.nstate)
  );

  drm_policy #(.QW(QW)) u_policy (
    .op       (op),
    .cur      (cur_st),
    .writable (req_writable),
    .q_occ    (q_occ),
    .q_thresh (q_thresh),
    .plan     (plan)
  );

  drm_cmd_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (seq_start),
    .start_clear (is_clear),
    .start_rd    (plan.do_rd),
    .start_wr    (plan.do_wr),
    .start_addr  (req_addr),
    .start_cnt   (req_count),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .cmd_write   (cmd_write),
    .cmd_addr    (cmd_addr),
    .busy        (busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= acc && plan.err;
  end

  assign err        = err_q;
  assign look_state = look_st;

  // R6: a clean eviction leaves the command port idle
  a_r6_clean_evict_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_evict && cur_st == LS_CLEAN) |=> !cmd_valid);

  // R7: eviction of a line whose memory is empty starts with a write
  a_r7_empty_evict_write: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_evict && cur_st == LS_DIRTY_EMPTY) |=> (cmd_valid && cmd_write && cmd_addr == $past(req_addr)));

  // R12: touching an invalid line raises the error pulse next cycle
  a_r12_err_follows_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (op == OP_EVICT || op == OP_STORE) && cur_st == LS_INVALID) |=> err);

  // R11: a request refused while busy leaves the command in flight untouched
  a_r11_busy_keeps_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cmd_ready && req_valid && op != OP_STORE) |=> (cmd_valid && $stable(cmd_addr)));

endmodule

// File: tb/drm_cycle_ctrl_tb.sv
module drm_cycle_ctrl_tb;

  localparam int LINES = 8;
  localparam int AW    = 12;
  localparam int CW    = 8;
  localparam int QW    = 4;
  localparam int IW    = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic [1:0]    req_op;
  logic [IW-1:0] req_slot;
  logic [AW-1:0] req_addr;
  logic          req_writable;
  logic [CW-1:0] req_count;
  logic [QW-1:0] q_occ;
  logic [QW-1:0] q_thresh;
  logic [IW-1:0] look_slot;
  logic [1:0]    look_state;
  logic          busy, err, cmd_valid, cmd_ready, cmd_write;
  logic [AW-1:0] cmd_addr;

  int checks = 0;
  int fails  = 0;
  logic [AW:0] got [16];
  int n_got;

  always #5 clk = ~clk;

  drm_cycle_ctrl #(.LINES(LINES), .ADDR_W(AW), .CNT_W(CW), .QW(QW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_slot(req_slot), .req_addr(req_addr), .req_writable(req_writable),
    .req_count(req_count), .q_occ(q_occ), .q_thresh(q_thresh),
    .look_slot(look_slot), .look_state(look_state), .busy(busy), .err(err),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW:0] rd_c(input logic [AW-1:0] a); return {1'b0, a}; endfunction
  function automatic logic [AW:0] wr_c(input logic [AW-1:0] a); return {1'b1, a}; endfunction

  task automatic send(input logic [1:0] op, input int slot, input logic [AW-1:0] a,
                      input logic wrt, input int cnt);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_slot = IW'(slot); req_addr = a;
    req_writable = wrt; req_count = CW'(cnt);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Takes commands until the port goes quiet; stall>0 holds ready low on some cycles.
  task automatic collect(input int stall);
    n_got = 0;
    for (int k = 0; k < 200; k++) begin
      if (!cmd_valid && !busy) break;
      cmd_ready = (stall == 0) || ((k % (stall + 1)) == stall);
      if (cmd_valid && cmd_ready && n_got < 16) begin
        got[n_got] = {cmd_write, cmd_addr};
        n_got++;
      end
      @(negedge clk);
    end
    cmd_ready = 1'b0;
  endtask

  task automatic state_is(input int slot, input logic [1:0] exp, input string req);
    look_slot = IW'(slot);
    #1;
    chk(look_state == exp, req, 32'(look_state), 32'(exp));
  endtask

  task automatic seq_is(input string req, input int n, input logic [AW:0] c0, input logic [AW:0] c1);
    chk(n_got == n, req, 32'(n_got), 32'(n));
    if (n > 0 && n_got > 0) chk(got[0] == c0, req, 32'(got[0]), 32'(c0));
    if (n > 1 && n_got > 1) chk(got[1] == c1, req, 32'(got[1]), 32'(c1));
  endtask

  task automatic t_reset();
    for (int s = 0; s < LINES; s++) state_is(s, 2'b00, "R1 state");
    chk(!busy && !cmd_valid && !err, "R1 outputs", {29'd0, busy, cmd_valid, err}, 32'd0);
  endtask

  task automatic t_ro_fill();
    send(2'b00, 0, 12'h010, 1'b0, 0);
    collect(0);
    seq_is("R2 ro fill cmds", 2, rd_c(12'h010), wr_c(12'h010));
    state_is(0, 2'b01, "R2 ro fill state");
  endtask

  task automatic t_wfill_low();
    q_occ = 4'd4; q_thresh = 4'd5;
    send(2'b00, 1, 12'h020, 1'b1, 0);
    collect(0);
    seq_is("R3 writable quiet cmds", 2, rd_c(12'h020), wr_c(12'h020));
    state_is(1, 2'b01, "R3 writable quiet state");
  endtask

  task automatic t_wfill_high();
    q_occ = 4'd5; q_thresh = 4'd5;
    send(2'b00, 2, 12'h030, 1'b1, 0);
    collect(0);
    seq_is("R4 writable busy-queue cmds", 1, rd_c(12'h030), '0);
    state_is(2, 2'b11, "R4 writable busy-queue state");
  endtask

  task automatic t_stores();
    send(2'b10, 0, 12'h0, 1'b0, 0);
    state_is(0, 2'b10, "R5 store clean");
    send(2'b10, 2, 12'h0, 1'b0, 0);
    state_is(2, 2'b11, "R5 store dirty unchanged");
    chk(!cmd_valid, "R5 store no cmd", 32'(cmd_valid), 32'd0);
  endtask

  task automatic t_evicts();
    send(2'b01, 1, 12'h020, 1'b0, 0);
    collect(0);
    seq_is("R6 clean evict cmds", 0, '0, '0);
    state_is(1, 2'b00, "R6 clean evict state");
    send(2'b01, 2, 12'h030, 1'b0, 0);
    collect(0);
    seq_is("R7 empty evict cmds", 1, wr_c(12'h030), '0);
    state_is(2, 2'b00, "R7 empty evict state");
    send(2'b01, 0, 12'h010, 1'b0, 0);
    collect(0);
    seq_is("R8 kept evict cmds", 2, rd_c(12'h010), wr_c(12'h010));
    state_is(0, 2'b00, "R8 kept evict state");
  endtask

  task automatic t_errors();
    send(2'b10, 5, 12'h0, 1'b0, 0);
    chk(err == 1'b1, "R12 store invalid err", 32'(err), 32'd1);
    state_is(5, 2'b00, "R12 store invalid state");
    send(2'b01, 5, 12'h050, 1'b0, 0);
    chk(err == 1'b1 && !cmd_valid, "R12 evict invalid", {30'd0, err, cmd_valid}, 32'd2);
    @(negedge clk);
    chk(err == 1'b0, "R12 err one cycle", 32'(err), 32'd0);
  endtask

  task automatic t_clear();
    send(2'b11, 0, 12'hFFE, 1'b0, 4);
    collect(2);
    chk(n_got == 4, "R9 clear count", 32'(n_got), 32'd4);
    for (int i = 0; i < 4; i++)
      if (i < n_got) chk(got[i] == rd_c(AW'(12'hFFE + i)), "R9 clear addr",
                         32'(got[i]), 32'(rd_c(AW'(12'hFFE + i))));
    for (int s = 0; s < LINES; s++) state_is(s, 2'b00, "R9 clear leaves table");
    send(2'b11, 0, 12'h100, 1'b0, 0);
    chk(!busy && !cmd_valid, "R9 zero clear", {30'd0, busy, cmd_valid}, 32'd0);
  endtask

  task automatic t_busy();
    send(2'b00, 3, 12'h040, 1'b0, 0);
    repeat (3) @(negedge clk);
    chk(cmd_valid && !cmd_write && cmd_addr == 12'h040, "R10 held cmd",
        {19'd0, cmd_valid, cmd_write, cmd_addr}, {19'd0, 1'b1, 1'b0, 12'h040});
    send(2'b00, 4, 12'h060, 1'b0, 0);
    state_is(4, 2'b00, "R11 fill ignored while busy");
    send(2'b10, 3, 12'h0, 1'b0, 0);
    state_is(3, 2'b10, "R5 store while busy");
    send(2'b11, 0, 12'h070, 1'b0, 2);
    collect(0);
    seq_is("R11 only first sequence", 2, rd_c(12'h040), wr_c(12'h040));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = 2'b00; req_slot = '0; req_addr = '0;
    req_writable = 1'b0; req_count = '0; q_occ = '0; q_thresh = 4'd8;
    look_slot = '0; cmd_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ro_fill();
    t_wfill_low();
    t_wfill_high();
    t_stores();
    t_evicts();
    t_errors();
    t_clear();
    t_busy();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule